// File: doc/BRIEF.md
# Readout Framing and Real-Time Interrupt Timer

This block is a free-running binary divider driven by the 1.25 MHz processor bus clock. Two of its stages serve two consumers. Bit 9 of the count is a square wave at one 1024th of the input clock, and it tells a display engine when to fetch its next subframe. Bit 12 is inverted to form an active-low real-time interrupt request. That request stays low for 4096 clock cycles, about 3.3 ms at the nominal clock.

Software restarts the divider while it services each interrupt. It raises a control bit, which clears the count and holds it at zero. It then drops the bit again, and counting resumes. The block also counts interrupts modulo ten. It decodes that count into two scheduling hints: a potentiometer-scan flag on every fifth interrupt, and a switch/overload-scan flag on every tenth interrupt. The tenth interrupt always carries the potentiometer flag as well.

Top module: `rt_frame_timer`

## Requirements
- R1: `frame_clk` equals bit 9 of the divider count. After `sw_clear` is released, `frame_clk` first goes high once 512 clock edges have passed. It is then a square wave with a period of 1024 cycles.
- R2: `irq_n` is low exactly while bit 12 of the 13-bit count is set. After release it first falls once 4096 edges have passed. When the divider runs free, it rises again 8192 edges after release, when the count wraps.
- R3: While `sw_clear` is high, the count is zero from the next edge onward, so `frame_clk` is 0 and `irq_n` is 1. After `sw_clear` falls, the count reads N once N edges have passed.
- R4: `task_idx` advances by one on the same edge on which `irq_n` falls, and it wraps from 9 to 0. It never leaves the range 0..9.
- R5: `pot_scan_due` is 1 after an interrupt has been seen and `task_idx` is 5 or 0. This makes it true on the 5th, 10th, 15th, and so on, interrupt since reset.
- R6: `sw_scan_due` is 1 after an interrupt has been seen and `task_idx` is 0, which is every 10th interrupt. Whenever it is 1, `pot_scan_due` is 1 too.
- R7: While `rst_n` is low, the outputs are `irq_n`=1, `frame_clk`=0, `task_idx`=0 and both flags 0. The reset asserts asynchronously and is released through a two-stage synchronizer.
- R8: `task_idx` and both flags hold their values between interrupts, and neither `sw_clear` nor counter wrap changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_e | input | 1 | 1.25 MHz bus clock, the only clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| sw_clear | input | 1 | Software control bit; high clears and holds the divider |
| frame_clk | output | 1 | Subframe load clock for the display engine (count bit 9) |
| irq_n | output | 1 | Active-low real-time interrupt request (inverted count bit 12) |
| task_idx | output | 4 | Interrupt cycle index, 0..9 |
| pot_scan_due | output | 1 | Potentiometer scan due on this interrupt cycle |
| sw_scan_due | output | 1 | Switch scan and overload check due on this interrupt cycle |

## Verification
Assertions check the following on every cycle:
- the divider steps by one unless it is being cleared,
- a raised `sw_clear` leaves the count at zero,
- the interrupt index steps with wrap only on an interrupt edge, holds otherwise, and stays in range,
- the switch-scan flag always implies the potentiometer flag.

The absolute timing cannot be seen from any single-cycle relation, and only the bench scenarios show it. That covers the 512- and 4096-edge distances from release and the wrap at 8192. It also covers which interrupt numbers carry each flag across more than one ten-interrupt round, and the idle output values during asynchronous reset.

// File: rtl/rt_timer_pkg.sv
package rt_timer_pkg;
  // Default tap positions and scheduling periods.
  localparam int unsigned FRAME_TAP_D  = 9;
  localparam int unsigned IRQ_TAP_D    = 12;
  localparam int unsigned TASK_LEN_D   = 10;
  localparam int unsigned POT_EVERY_D  = 5;

  // Step of a wrapping modulo counter.
  function automatic logic [7:0] wrap_inc(input logic [7:0] v, input logic [7:0] last);
    return (v == last) ? 8'd0 : v + 8'd1;
  endfunction
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_no = stage1_q;
endmodule

// File: rtl/rt_div_chain.sv
module rt_div_chain #(
  parameter int unsigned IRQ_TAP = rt_timer_pkg::IRQ_TAP_D,
  localparam int unsigned CNT_W  = IRQ_TAP + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Next-state logic
  always_comb begin
    cnt_en = 1'b1;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  // Interrupt edge: the low stages are all ones and the tap stage is about to set.
  assign irq_evt = !clr && (&cnt_q[IRQ_TAP-1:0]) && !cnt_q[IRQ_TAP];

  // Register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: a raised clear leaves the divider at zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));

  // R1 / R2: free counting advances by exactly one, wrapping at the top
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R2: an interrupt edge is followed by the tap stage being set
  a_r2_irq_tap_set: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_evt |=> cnt_q[IRQ_TAP]);
endmodule

// File: rtl/rt_task_sched.sv
module rt_task_sched #(
  parameter int unsigned TASK_LEN  = rt_timer_pkg::TASK_LEN_D,
  parameter int unsigned POT_EVERY = rt_timer_pkg::POT_EVERY_D,
  localparam int unsigned IDX_W    = $clog2(TASK_LEN)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             irq_evt,
  output logic [IDX_W-1:0] idx_q,
  output logic             pot_due,
  output logic             sw_due
);
  localparam logic [7:0] LAST_IDX = 8'(TASK_LEN - 1);

  logic [IDX_W-1:0] idx_d;
  logic             seen_q, seen_d;
  logic [7:0]       idx_wide;

  // Next-state logic
  always_comb begin
    idx_wide = rt_timer_pkg::wrap_inc(8'(idx_q), LAST_IDX);
    idx_d    = idx_q;
    seen_d   = seen_q;
    if (irq_evt) begin
      idx_d  = idx_wide[IDX_W-1:0];
      seen_d = 1'b1;
    end
  end

  // Register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      seen_q <= seen_d;
    end
  end

  // Decodes
  assign sw_due  = seen_q && (idx_q == '0);
  assign pot_due = seen_q && ((32'(idx_q) % POT_EVERY) == 0);

  // R4: interrupt edge steps the index with wrap
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_evt |=> (idx_q == (($past(idx_q) == IDX_W'(TASK_LEN - 1)) ? '0 : IDX_W'($past(idx_q) + 1'b1))));

  // R4: index stays inside its range
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_ni)
    32'(idx_q) < TASK_LEN);

  // R8: index holds between interrupt edges
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !irq_evt |=> $stable(idx_q));

  // R6: switch scan always comes with a potentiometer scan
  a_r6_sw_implies_pot: assert property (@(posedge clk) disable iff (!rst_ni)
    sw_due |-> pot_due);
endmodule

// File: rtl/rt_frame_timer.sv
module rt_frame_timer #(
  parameter int unsigned FRAME_TAP = rt_timer_pkg::FRAME_TAP_D,
  parameter int unsigned IRQ_TAP   = rt_timer_pkg::IRQ_TAP_D,
  parameter int unsigned TASK_LEN  = rt_timer_pkg::TASK_LEN_D,
  parameter int unsigned POT_EVERY = rt_timer_pkg::POT_EVERY_D,
  localparam int unsigned CNT_W    = IRQ_TAP + 1,
  localparam int unsigned IDX_W    = $clog2(TASK_LEN)
) (
  input  logic             clk_e,
  input  logic             rst_n,
  input  logic             sw_clear,
  output logic             frame_clk,
  output logic             irq_n,
  output logic [IDX_W-1:0] task_idx,
  output logic             pot_scan_due,
  output logic             sw_scan_due
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic             irq_evt;

  rt_rst_sync u_rst (
    .clk         (clk_e),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  rt_div_chain #(.IRQ_TAP(IRQ_TAP)) u_div (
    .clk     (clk_e),
    .rst_ni  (rst_sync_n),
    .clr     (sw_clear),
    .cnt_q   (cnt),
    .irq_evt (irq_evt)
  );

  rt_task_sched #(.TASK_LEN(TASK_LEN), .POT_EVERY(POT_EVERY)) u_sched (
    .clk     (clk_e),
    .rst_ni  (rst_sync_n),
    .irq_evt (irq_evt),
    .idx_q   (task_idx),
    .pot_due (pot_scan_due),
    .sw_due  (sw_scan_due)
  );

  assign frame_clk = cnt[FRAME_TAP];
  assign irq_n     = ~cnt[IRQ_TAP];

  // R2: interrupt request falls only on a counted interrupt edge
  a_r2_irq_fall_evt: assert property (@(posedge clk_e) disable iff (!rst_sync_n)
    $fell(irq_n) |-> $past(irq_evt));
endmodule

// File: tb/rt_frame_timer_tb.sv
module rt_frame_timer_tb_top;
  logic       clk_e = 1'b0;
  logic       rst_n;
  logic       sw_clear;
  logic       frame_clk, irq_n, pot_scan_due, sw_scan_due;
  logic [3:0] task_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_e = ~clk_e;

  rt_frame_timer dut_i (
    .clk_e(clk_e), .rst_n(rst_n), .sw_clear(sw_clear),
    .frame_clk(frame_clk), .irq_n(irq_n), .task_idx(task_idx),
    .pot_scan_due(pot_scan_due), .sw_scan_due(sw_scan_due)
  );

  // Vector: {edges since release [15:0], expected frame_clk, expected irq_n}
  localparam int NV = 11;
  localparam logic [17:0] VECS [0:NV-1] = '{
    {16'd1,    1'b0, 1'b1},
    {16'd511,  1'b0, 1'b1},
    {16'd512,  1'b1, 1'b1},
    {16'd1023, 1'b1, 1'b1},
    {16'd1024, 1'b0, 1'b1},
    {16'd1536, 1'b1, 1'b1},
    {16'd4095, 1'b1, 1'b1},
    {16'd4096, 1'b0, 1'b0},
    {16'd4608, 1'b1, 1'b0},
    {16'd8191, 1'b1, 1'b0},
    {16'd8192, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_e);
    @(negedge clk_e);
  endtask

  initial begin
    rst_n = 1'b0;
    sw_clear = 1'b1;
    #23;
    // R7: reset state
    check("R7 irq_n", irq_n, 1);
    check("R7 frame_clk", frame_clk, 0);
    check("R7 task_idx", task_idx, 0);
    check("R7 pot_scan_due", pot_scan_due, 0);
    check("R7 sw_scan_due", sw_scan_due, 0);
    @(negedge clk_e); rst_n = 1'b1;
    step(5);
    sw_clear = 1'b0;

    // R1 / R2 vector walk from release, running free
    begin
      int now = 0;
      for (int i = 0; i < NV; i++) begin
        int n;
        n = int'(VECS[i][17:2]);
        step(n - now);
        now = n;
        check("R1 frame_clk", frame_clk, int'(VECS[i][1]));
        check("R2 irq_n", irq_n, int'(VECS[i][0]));
        if (n == 4095) check("R8 idx before irq", task_idx, 0);
        if (n == 4096) check("R4 idx after irq", task_idx, 1);
        if (n == 8192) check("R8 idx after wrap", task_idx, 1);
      end
    end

    // R3: clear while irq is low
    step(4096);
    check("R3 irq low before clear", irq_n, 0);
    check("R4 second irq", task_idx, 2);
    sw_clear = 1'b1;
    step(1);
    check("R3 irq released", irq_n, 1);
    check("R3 frame low", frame_clk, 0);
    step(6000);
    check("R3 held irq", irq_n, 1);
    check("R8 idx stable during clear", task_idx, 2);
    sw_clear = 1'b0;
    step(512);
    check("R3 resume frame", frame_clk, 1);
    step(3583);
    check("R3 resume irq not yet", irq_n, 1);
    step(1);
    check("R3 resume irq", irq_n, 0);
    check("R4 third irq", task_idx, 3);

    // R4/R5/R6: service-style restart each interrupt, irqs 4..13
    for (int k = 4; k <= 13; k++) begin
      sw_clear = 1'b1;
      step(1);
      sw_clear = 1'b0;
      step(4096);
      check("R4 idx", task_idx, k % 10);
      check("R5 pot_scan_due", pot_scan_due, (k % 5 == 0) ? 1 : 0);
      check("R6 sw_scan_due", sw_scan_due, (k % 10 == 0) ? 1 : 0);
      if (k == 10) begin
        step(2000);
        check("R8 flags held", sw_scan_due, 1);
      end
    end

    // R7: async reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check("R7 async idx", task_idx, 0);
    check("R7 async irq_n", irq_n, 1);
    check("R7 async flags", pot_scan_due | sw_scan_due, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk_e);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule